// File: doc/BRIEF.md
# DMA Thread Security Checker

This block sits beside the instruction decoder of a multi-channel DMA engine. It judges every event or peripheral instruction against the security state of the thread that issued it. Each channel carries a non-secure flag. Each event and each peripheral carries a non-secure configuration bit. A secure thread may use any resource. A non-secure thread may use only resources whose bit is 1. Any other access is turned into a no-operation and logged as a fault.

One instruction is presented per cycle as a channel number, an opcode and a resource index. One cycle later the block reports whether the instruction proceeds, stalls or faults. A stalled channel keeps its wait condition and is released on the first cycle in which its event or peripheral request is present. A faulted channel passes through a completing state into a faulted state. It keeps its sticky fault-source and event-error bits until a per-channel clear pulse arrives.

The block keeps the pending-event flags itself. A wait on an event consumes the flag. A permitted send-event raises a one-cycle interrupt pulse on its event line.

Top module: `dma_sec_chk`

## Requirements
- R1: A channel whose `ch_nonsec` bit is 0 never faults. Every opcode it issues is allowed whatever the event or peripheral security bits hold.
- R2: For a channel whose `ch_nonsec` bit is 1, opcodes 0 (wait-for-event) and 1 (send-event) are allowed when `evt_nonsec[ins_idx]` is 1. They fault when it is 0.
- R3: For a channel whose `ch_nonsec` bit is 1, opcodes 2 to 7 form the peripheral class. Opcode 2 is wait, 3 is load, 4 is flush, 5 is stop, and 6 and 7 are treated as peripheral instructions. They are allowed when `peri_nonsec[ins_idx]` is 1 and fault when it is 0.
- R4: An accepted instruction produces `dec_valid` high in the following cycle, with `dec_ch` equal to the issuing channel. `dec_code` is 0 for proceed, 1 for stall and 2 for fault.
- R5: An allowed wait-for-event proceeds if its event is already pending or is set in the same cycle, and consumes that event. Otherwise it stalls. An allowed wait-for-peripheral proceeds if `peri_req[ins_idx]` is high and otherwise stalls. All other allowed opcodes proceed.
- R6: A stalled channel shows state 1 in `ch_state` (2 bits per channel: 0 run, 1 wait, 2 faulting-completing, 3 faulted). On the first cycle its event (pending or newly set) or peripheral request is high, it returns to state 0 in the next cycle with a one-cycle `ch_release` pulse. A released event wait clears that pending event.
- R7: A fault reports `dec_code` 2 and raises no interrupt. It sets `flt_src` and `flt_evt_err` for the channel and moves the channel to state 2. The channel enters state 3 on the next cycle unless a clear arrives.
- R8: Fault bits are sticky. A `flt_clr` pulse clears them and returns a channel in state 2 or 3 to state 0. A fault that is logged in the same cycle as a clear for its channel takes priority: the bits stay set.
- R9: An instruction for a channel that is not in state 0 is dropped. No `dec_valid` appears and no state, fault bit, pending event or interrupt changes.
- R10: An allowed send-event drives `evt_irq[ins_idx]` high for exactly one cycle, aligned with its `dec_valid`. At most one interrupt bit is high at a time.
- R11: An `evt_set` pulse sets the matching `evt_pend` bit on the next cycle. The bit stays set until an event wait consumes it.
- R12: After reset all outputs are zero and every channel is in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction strobe |
| ins_ch | input | CHW | Issuing channel |
| ins_op | input | 3 | Opcode (0 wait-event, 1 send-event, 2 wait-periph, 3 load, 4 flush, 5 stop) |
| ins_idx | input | IDXW | Event or peripheral index |
| ch_nonsec | input | NUM_CH | Per-channel non-secure flag |
| evt_nonsec | input | NUM_EVT | Per-event non-secure configuration |
| peri_nonsec | input | NUM_PERI | Per-peripheral non-secure configuration |
| evt_set | input | NUM_EVT | Event occurrence pulses |
| peri_req | input | NUM_PERI | Live peripheral request lines |
| flt_clr | input | NUM_CH | Per-channel fault clear pulse |
| dec_valid | output | 1 | Decision valid |
| dec_ch | output | CHW | Channel of the decision |
| dec_code | output | 2 | 0 proceed, 1 stall, 2 fault |
| evt_irq | output | NUM_EVT | Event interrupt pulses |
| ch_release | output | NUM_CH | Stall release pulses |
| ch_state | output | 2*NUM_CH | Per-channel state |
| flt_src | output | NUM_CH | Sticky fault-source bits |
| flt_evt_err | output | NUM_CH | Sticky event-error fault-type bits |
| evt_pend | output | NUM_EVT | Pending event flags |

## Verification
Two collisions matter. The first is a fault on a channel in the same cycle as a clear for that channel. The second is a new event wait, or a stall release, in the same cycle as the `evt_set` pulse it depends on. Directed steps raise the clear together with a non-secure load to a secure peripheral. They also pulse an event while two channels wait on it and a third issues a wait for it. A behavioural model in the bench computes the expected outcome of each collision: the fault bits stay set, and the event is consumed without ever appearing as pending. A long stretch of random traffic then compares every output against the model on every clock.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   typedef enum logic [2:0] {
      OP_WFE = 3'd0,
      OP_SEV = 3'd1,
      OP_WFP = 3'd2,
      OP_LDP = 3'd3,
      OP_FLP = 3'd4,
      OP_STP = 3'd5
   } op_e;

   typedef enum logic [1:0] {
      RES_GO    = 2'd0,
      RES_STALL = 2'd1,
      RES_FAULT = 2'd2
   } res_e;

   typedef enum logic [1:0] {
      CH_RUN   = 2'd0,
      CH_WAIT  = 2'd1,
      CH_FCOMP = 2'd2,
      CH_FAULT = 2'd3
   } chst_e;

endpackage

// File: rtl/dsc_access_chk.sv
module dsc_access_chk
   import dsc_pkg::*;
#(
   parameter int MAXN = 32,
   parameter int IDXW = 5
) (
   input  logic            ch_ns_i,
   input  logic [2:0]      op_i,
   input  logic [IDXW-1:0] idx_i,
   input  logic [MAXN-1:0] evt_ns_i,
   input  logic [MAXN-1:0] peri_ns_i,
   input  logic [MAXN-1:0] evt_live_i,
   input  logic [MAXN-1:0] peri_live_i,
   output logic            allowed_o,
   output logic            is_evt_o,
   output logic [1:0]      code_o
);

   op_e  op;
   logic res_bit;
   logic ready;

   assign op       = op_e'(op_i);
   assign is_evt_o = (op == OP_WFE) || (op == OP_SEV);
   assign res_bit  = is_evt_o ? evt_ns_i[idx_i] : peri_ns_i[idx_i];
   assign allowed_o = !ch_ns_i || res_bit;

   always_comb begin
      case (op)
         OP_WFE:  ready = evt_live_i[idx_i];
         OP_WFP:  ready = peri_live_i[idx_i];
         default: ready = 1'b1;
      endcase
      if (!allowed_o)  code_o = RES_FAULT;
      else if (!ready) code_o = RES_STALL;
      else             code_o = RES_GO;
   end

endmodule

// File: rtl/dsc_evt_pend.sv
module dsc_evt_pend #(
   parameter int NUM_EVT = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] set_i,
   input  logic [NUM_EVT-1:0] cons_i,
   output logic [NUM_EVT-1:0] pend_o,
   output logic [NUM_EVT-1:0] live_o
);

   assign live_o = pend_o | set_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= live_o & ~cons_i;
   end

   AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((pend_o & $past(set_i & ~cons_i)) == $past(set_i & ~cons_i))); // R11

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pend_o & ~cons_i)) |=> ((pend_o & $past(pend_o & ~cons_i)) == $past(pend_o & ~cons_i))); // R11

endmodule

// File: rtl/dsc_chan.sv
module dsc_chan
   import dsc_pkg::*;
#(
   parameter int MAXN = 32,
   parameter int IDXW = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue_i,
   input  logic [1:0]      code_i,
   input  logic            is_evt_i,
   input  logic [IDXW-1:0] idx_i,
   input  logic [MAXN-1:0] evt_live_i,
   input  logic [MAXN-1:0] peri_live_i,
   input  logic            clr_i,
   output logic [1:0]      state_o,
   output logic            fsrc_o,
   output logic            ferr_o,
   output logic            rel_o,
   output logic [MAXN-1:0] cons_o
);

   chst_e           st;
   logic            w_evt;
   logic [IDXW-1:0] w_idx;
   logic            hit;
   logic            set_flt;

   assign state_o = st;
   assign set_flt = issue_i && (code_i == RES_FAULT);
   assign hit     = (st == CH_WAIT) &&
                    (w_evt ? evt_live_i[w_idx] : peri_live_i[w_idx]);
   assign cons_o  = (hit && w_evt) ? (MAXN'(1) << w_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= CH_RUN;
         w_evt  <= 1'b0;
         w_idx  <= '0;
         rel_o  <= 1'b0;
         fsrc_o <= 1'b0;
         ferr_o <= 1'b0;
      end else begin
         rel_o <= hit;
         if (set_flt) begin
            fsrc_o <= 1'b1;
            ferr_o <= 1'b1;
         end else if (clr_i) begin
            fsrc_o <= 1'b0;
            ferr_o <= 1'b0;
         end
         case (st)
            CH_RUN: begin
               if (set_flt) begin
                  st <= CH_FCOMP;
               end else if (issue_i && (code_i == RES_STALL)) begin
                  st    <= CH_WAIT;
                  w_evt <= is_evt_i;
                  w_idx <= idx_i;
               end
            end
            CH_WAIT:  if (hit) st <= CH_RUN;
            CH_FCOMP: st <= clr_i ? CH_RUN : CH_FAULT;
            CH_FAULT: if (clr_i) st <= CH_RUN;
            default:  st <= CH_RUN;
         endcase
      end
   end

   AST_FAULT_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
      set_flt |=> (fsrc_o && ferr_o && st == CH_FCOMP)); // R7

   AST_FCOMP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CH_FCOMP && !clr_i) |=> (st == CH_FAULT)); // R7

   AST_FLT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fsrc_o && !clr_i) |=> fsrc_o); // R8

   AST_REL_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      rel_o |-> (st == CH_RUN && $past(st) == CH_WAIT)); // R6

endmodule

// File: rtl/dma_sec_chk.sv
module dma_sec_chk
   import dsc_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int NUM_EVT  = 32,
   parameter int NUM_PERI = 32,
   localparam int CHW  = $clog2(NUM_CH),
   localparam int MAXN = (NUM_EVT > NUM_PERI) ? NUM_EVT : NUM_PERI,
   localparam int IDXW = $clog2(MAXN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ins_valid,
   input  logic [CHW-1:0]      ins_ch,
   input  logic [2:0]          ins_op,
   input  logic [IDXW-1:0]     ins_idx,
   input  logic [NUM_CH-1:0]   ch_nonsec,
   input  logic [NUM_EVT-1:0]  evt_nonsec,
   input  logic [NUM_PERI-1:0] peri_nonsec,
   input  logic [NUM_EVT-1:0]  evt_set,
   input  logic [NUM_PERI-1:0] peri_req,
   input  logic [NUM_CH-1:0]   flt_clr,
   output logic                dec_valid,
   output logic [CHW-1:0]      dec_ch,
   output logic [1:0]          dec_code,
   output logic [NUM_EVT-1:0]  evt_irq,
   output logic [NUM_CH-1:0]   ch_release,
   output logic [2*NUM_CH-1:0] ch_state,
   output logic [NUM_CH-1:0]   flt_src,
   output logic [NUM_CH-1:0]   flt_evt_err,
   output logic [NUM_EVT-1:0]  evt_pend
);

   generate
      if (NUM_CH < 2 || NUM_EVT < 2 || NUM_PERI < 2) begin : g_bad_cfg
         $error("dma_sec_chk: NUM_CH, NUM_EVT and NUM_PERI must each be at least 2");
      end
   endgenerate

   logic [NUM_EVT-1:0] evt_live;
   logic [NUM_EVT-1:0] cons_all;
   logic [MAXN-1:0]    evt_live_p, peri_live_p, evt_ns_p, peri_ns_p;
   logic [MAXN-1:0]    cons_imm, cons_or;
   logic [MAXN-1:0]    cons_ch [NUM_CH];
   logic [1:0]         st_ch   [NUM_CH];
   logic               allowed, is_evt, ns_sel, ch_ok, accept;
   logic [1:0]         code;
   logic [MAXN-1:0]    irq_next;

   assign evt_live_p  = MAXN'(evt_live);
   assign peri_live_p = MAXN'(peri_req);
   assign evt_ns_p    = MAXN'(evt_nonsec);
   assign peri_ns_p   = MAXN'(peri_nonsec);

   assign ch_ok  = int'(ins_ch) < NUM_CH;
   assign ns_sel = ch_ok ? ch_nonsec[ins_ch] : 1'b0;
   assign accept = ins_valid && ch_ok && (st_ch[ins_ch] == CH_RUN);

   dsc_access_chk #(.MAXN(MAXN), .IDXW(IDXW)) u_acc (
      .ch_ns_i     (ns_sel),
      .op_i        (ins_op),
      .idx_i       (ins_idx),
      .evt_ns_i    (evt_ns_p),
      .peri_ns_i   (peri_ns_p),
      .evt_live_i  (evt_live_p),
      .peri_live_i (peri_live_p),
      .allowed_o   (allowed),
      .is_evt_o    (is_evt),
      .code_o      (code)
   );

   assign cons_imm = (accept && allowed && ins_op == OP_WFE && evt_live_p[ins_idx])
                     ? (MAXN'(1) << ins_idx) : '0;
   assign irq_next = (accept && allowed && ins_op == OP_SEV)
                     ? (MAXN'(1) << ins_idx) : '0;

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_ch
         dsc_chan #(.MAXN(MAXN), .IDXW(IDXW)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .issue_i     (accept && (int'(ins_ch) == g)),
            .code_i      (code),
            .is_evt_i    (is_evt),
            .idx_i       (ins_idx),
            .evt_live_i  (evt_live_p),
            .peri_live_i (peri_live_p),
            .clr_i       (flt_clr[g]),
            .state_o     (st_ch[g]),
            .fsrc_o      (flt_src[g]),
            .ferr_o      (flt_evt_err[g]),
            .rel_o       (ch_release[g]),
            .cons_o      (cons_ch[g])
         );
         assign ch_state[2*g +: 2] = st_ch[g];
      end
   endgenerate

   always_comb begin
      cons_or = cons_imm;
      for (int c = 0; c < NUM_CH; c++) cons_or = cons_or | cons_ch[c];
   end
   assign cons_all = cons_or[NUM_EVT-1:0];

   dsc_evt_pend #(.NUM_EVT(NUM_EVT)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_set),
      .cons_i (cons_all),
      .pend_o (evt_pend),
      .live_o (evt_live)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_ch    <= '0;
         dec_code  <= RES_GO;
         evt_irq   <= '0;
      end else begin
         dec_valid <= accept;
         dec_ch    <= ins_ch;
         dec_code  <= code;
         evt_irq   <= irq_next[NUM_EVT-1:0];
      end
   end

   AST_DEC_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> $past(ins_valid)); // R4

   AST_SECURE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_code == RES_FAULT) |-> $past(ns_sel)); // R1

   AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt_irq)); // R10

   AST_IRQ_ONLY_PROCEED: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_irq) |-> (dec_valid && dec_code == RES_GO)); // R10

endmodule

// File: tb/dma_sec_chk_bench.sv
module dma_sec_chk_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ins_valid;
   logic [2:0]  ins_ch;
   logic [2:0]  ins_op;
   logic [4:0]  ins_idx;
   logic [7:0]  ch_nonsec;
   logic [31:0] evt_nonsec, peri_nonsec, evt_set, peri_req;
   logic [7:0]  flt_clr;
   logic        dec_valid;
   logic [2:0]  dec_ch;
   logic [1:0]  dec_code;
   logic [31:0] evt_irq, evt_pend;
   logic [7:0]  ch_release, flt_src, flt_evt_err;
   logic [15:0] ch_state;

   always #2 clk = ~clk;

   dma_sec_chk u_dma_sec_chk (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ch(ins_ch),
      .ins_op(ins_op), .ins_idx(ins_idx), .ch_nonsec(ch_nonsec),
      .evt_nonsec(evt_nonsec), .peri_nonsec(peri_nonsec), .evt_set(evt_set),
      .peri_req(peri_req), .flt_clr(flt_clr), .dec_valid(dec_valid),
      .dec_ch(dec_ch), .dec_code(dec_code), .evt_irq(evt_irq),
      .ch_release(ch_release), .ch_state(ch_state), .flt_src(flt_src),
      .flt_evt_err(flt_evt_err), .evt_pend(evt_pend)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 0;
   string phase = "R12 reset";

   // behavioural reference state
   int          m_st   [8];
   bit          m_wevt [8];
   int          m_widx [8];
   logic [7:0]  m_fsrc, m_ferr, e_rel;
   logic [31:0] m_pend, e_irq;
   bit          e_dv;
   int          e_ch, e_code;

   task automatic model_reset();
      for (int c = 0; c < 8; c++) begin m_st[c] = 0; m_wevt[c] = 0; m_widx[c] = 0; end
      m_fsrc = '0; m_ferr = '0; m_pend = '0; e_rel = '0; e_irq = '0;
      e_dv = 0; e_ch = 0; e_code = 0;
   endtask

   task automatic model_step();
      logic [31:0] live, npend;
      int  nst [8];
      bit  acc, ok, isev;
      int  ch, op, idx, code;
      live  = m_pend | evt_set;
      npend = live;
      e_rel = '0; e_irq = '0; code = 0;
      for (int c = 0; c < 8; c++) begin
         nst[c] = m_st[c];
         if (m_st[c] == 1) begin
            if (m_wevt[c] ? live[m_widx[c]] : peri_req[m_widx[c]]) begin
               e_rel[c] = 1'b1;
               nst[c]   = 0;
               if (m_wevt[c]) npend[m_widx[c]] = 1'b0;
            end
         end
      end
      ch = int'(ins_ch); op = int'(ins_op); idx = int'(ins_idx);
      acc = ins_valid && (m_st[ch] == 0);
      if (acc) begin
         isev = (op < 2);
         ok   = !ch_nonsec[ch] || (isev ? evt_nonsec[idx] : peri_nonsec[idx]);
         if (!ok) code = 2;
         else if (op == 0 && !live[idx]) code = 1;
         else if (op == 2 && !peri_req[idx]) code = 1;
         else code = 0;
         if (ok && op == 0 && live[idx]) npend[idx] = 1'b0;
         if (ok && op == 1) e_irq[idx] = 1'b1;
      end
      for (int c = 0; c < 8; c++) begin
         bit fault_here;
         fault_here = acc && (c == ch) && (code == 2);
         if (fault_here) begin
            m_fsrc[c] = 1'b1; m_ferr[c] = 1'b1; nst[c] = 2;
         end else begin
            if (flt_clr[c]) begin m_fsrc[c] = 1'b0; m_ferr[c] = 1'b0; end
            if (m_st[c] == 2) nst[c] = flt_clr[c] ? 0 : 3;
            if (m_st[c] == 3 && flt_clr[c]) nst[c] = 0;
            if (acc && c == ch && code == 1) begin
               nst[c] = 1; m_wevt[c] = (op == 0); m_widx[c] = idx;
            end
         end
      end
      for (int c = 0; c < 8; c++) m_st[c] = nst[c];
      m_pend = npend;
      e_dv = acc; e_ch = ch; e_code = code;
   endtask

   task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s (step: %s) act=%h exp=%h at %0t", req, what, phase, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic [15:0] est;
      for (int c = 0; c < 8; c++) est[2*c +: 2] = 2'(m_st[c]);
      cmp("R4", "dec_valid", 32'(dec_valid), 32'(e_dv));
      if (e_dv) begin
         cmp("R4", "dec_ch", 32'(dec_ch), 32'(e_ch));
         cmp("R4", "dec_code", 32'(dec_code), 32'(e_code));
      end
      cmp("R10", "evt_irq", evt_irq, e_irq);
      cmp("R6", "ch_release", 32'(ch_release), 32'(e_rel));
      cmp("R6", "ch_state", 32'(ch_state), 32'(est));
      cmp("R7", "flt_src", 32'(flt_src), 32'(m_fsrc));
      cmp("R7", "flt_evt_err", 32'(flt_evt_err), 32'(m_ferr));
      cmp("R11", "evt_pend", evt_pend, m_pend);
   endtask

   task automatic tick();
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic issue(int ch, int op, int idx);
      ins_valid = 1'b1; ins_ch = 3'(ch); ins_op = 3'(op); ins_idx = 5'(idx);
      tick();
      ins_valid = 1'b0; evt_set = '0; peri_req = '0; flt_clr = '0;
   endtask

   task automatic pulse_evt(int idx);
      evt_set = 32'(1) << idx; tick(); evt_set = '0;
   endtask

   task automatic pulse_clr(int ch);
      flt_clr = 8'(1) << ch; tick(); flt_clr = '0;
   endtask

   initial begin
      rst_n = 1'b0; ins_valid = 1'b0; ins_ch = '0; ins_op = '0; ins_idx = '0;
      ch_nonsec = '0; evt_nonsec = '0; peri_nonsec = '0; evt_set = '0;
      peri_req = '0; flt_clr = '0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare_all();                                   // R12 reset values
      idle(2);

      phase = "R1 R5 secure wait-for-event stalls";
      issue(0, 0, 3); idle(2);
      phase = "R6 stalled channel released by event";
      pulse_evt(3); idle(2);
      phase = "R1 R10 secure send-event";
      issue(0, 1, 5); idle(1);
      phase = "R1 R5 secure peripheral wait then release R6";
      issue(0, 2, 7); idle(1);
      peri_req[7] = 1'b1; tick(); peri_req = '0; idle(1);
      phase = "R1 R3 secure load, flush, stop";
      issue(0, 3, 1); issue(0, 4, 2); issue(0, 5, 3); idle(1);
      phase = "R11 R5 pending event consumed by later wait";
      pulse_evt(9); idle(2); issue(1, 0, 9); idle(2);

      ch_nonsec = 8'b0000_1100;
      evt_nonsec = 32'h0000_0010;
      peri_nonsec = 32'h0000_0400;
      phase = "R2 R5 non-secure wait with same-cycle event";
      evt_set[4] = 1'b1; issue(2, 0, 4); idle(1);
      phase = "R2 R10 non-secure send to non-secure event";
      issue(2, 1, 4); idle(1);
      phase = "R2 R7 non-secure send to secure event faults";
      issue(2, 1, 6); idle(2);
      phase = "R9 instruction to faulted channel dropped";
      issue(2, 1, 4); idle(1);
      phase = "R8 clear returns channel to run";
      idle(2); pulse_clr(2); idle(1);
      phase = "R3 non-secure peripheral allowed and denied";
      peri_req[10] = 1'b1; issue(3, 2, 10); issue(3, 5, 10);
      issue(3, 4, 12); idle(2); pulse_clr(3); idle(1);
      phase = "R8 fault and clear in the same cycle";
      flt_clr[3] = 1'b1; issue(3, 3, 11); idle(3); pulse_clr(3); idle(1);
      phase = "R9 R6 two waiters released together";
      issue(0, 0, 20); issue(0, 1, 5); issue(1, 0, 20); idle(1);
      evt_set[20] = 1'b1; issue(4, 0, 20); idle(2);
      phase = "R3 spare opcodes use peripheral class";
      issue(0, 6, 1); issue(2, 7, 12); idle(2); pulse_clr(2); idle(1);

      phase = "R1 R2 R3 R5 R6 R7 R8 R9 R10 R11 random traffic";
      for (int i = 0; i < 3000; i++) begin
         ins_valid   = 1'($urandom % 2);
         ins_ch      = 3'($urandom);
         ins_op      = 3'($urandom);
         ins_idx     = 5'($urandom);
         if (i % 50 == 0) begin
            ch_nonsec   = 8'($urandom);
            evt_nonsec  = $urandom;
            peri_nonsec = $urandom;
         end
         evt_set  = $urandom & $urandom & $urandom;
         peri_req = $urandom & $urandom & $urandom;
         flt_clr  = 8'($urandom & $urandom & $urandom);
         tick();
      end
      ins_valid = 1'b0; evt_set = '0; peri_req = '0; flt_clr = '0;
      idle(4);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R4 watchdog act=running exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule